// File: doc/BRIEF.md
# USB Host Controller Interrupt Register Set

This block collects the event pulses raised by the rest of a USB 1.1 host controller and turns them into one level interrupt for the system. Each source latches into a sticky status bit. Software clears a status bit by writing 1 to it.

Enable bits are never written directly. Software sets them through one alias that only sets bits, and clears them through a second alias that only clears bits. A master enable gates every source, so software can mask the controller as a whole without losing its per-source choices.

A small command word sits beside the interrupt registers. It holds:
- a 2-bit scheduling-overrun counter,
- two list-filled flags,
- an ownership-change request,
- a self-timed software reset.

Software reaches all of this through a plain single-cycle register port. Reads are combinational on the word address.

Top module: `usb_hc_irq_regs`

## Requirements
- R1: After `rst_n` is low at a clock edge, every register reads 0 and `irq` is 0.
- R2: A one-cycle pulse on `evt[i]` sets status bit i (STAT word, address 0x0, bit i for i = 0..6) at that edge. The bit stays set with no further pulses. Source order is: 0 overrun, 1 done-list written, 2 frame start, 3 resume, 4 unrecoverable error, 5 frame-number overflow, 6 root-hub change.
- R3: Writing STAT clears each status bit (0..6 and 30) that has a 1 in the written data and leaves the others unchanged. If an event and a clear meet on the same bit in one cycle, the bit stays set.
- R4: Writing the set alias (address 0x4) sets each enable bit with a 1 in the data: bits 0..6 for sources, bit 30 for ownership change, bit 31 for master. Zeros leave bits unchanged. Address 0x4 reads back the enable bits.
- R5: Writing the clear alias (address 0x8) clears each enable bit with a 1 in the data. Address 0x8 always reads 0.
- R6: At each edge, `irq` takes the value (master enable) AND OR over (status AND enable), using the register state from before that edge. It therefore changes one cycle after the status or enable state changes.
- R7: Writing 1 to CMD (address 0xC) bit 3 stores the ownership request and sets ownership-change status bit 30 of STAT. Bit 30 is enabled by enable bit 30.
- R8: Each pulse on `evt[0]` increments the 2-bit overrun count, read at CMD bits 17:16. The count wraps from 3 to 0.
- R9: CMD bit 1 (control list filled), bit 2 (bulk list filled) and bit 3 (ownership request) load from the data on every CMD write.
- R10: Writing 1 to CMD bit 0 starts a software reset. Bit 0 reads 1 for exactly 8 cycles after that edge. Status, enables, counter and flags are cleared at that edge and at each of the 8 cycles. Writes and events during those cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 4 | Byte address; bits 3:2 select the word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| evt | input | 7 | Single-cycle event pulses, one per source |
| irq | output | 1 | Registered level interrupt |

## Verification
Each source is pulsed alone so that status bit positions can be told apart. Clears are then written with partial masks, which separates write-one-to-clear from a plain load. One cycle lands an event and a clear on the same bit, which tells event priority from clear priority. The enable aliases are driven with overlapping set and clear masks, and the master bit is toggled while sources are pending, which shows gating versus per-source masking. Five back-to-back overrun pulses expose the counter wrap. A software reset is issued with events and writes arriving during its window, which shows that the state is held cleared for the full window. A random phase then mixes all of these against the cycle model.

// File: rtl/usb_hc_irq_pkg.sv
// Shared constants for the host controller interrupt register set.
// Assumes 32-bit register words addressed by byte address bits 3:2.
package usb_hc_irq_pkg;
    localparam int NUM_SRC  = 7;
    localparam int DATA_W   = 32;
    localparam int OC_BIT   = 30;
    localparam int MIE_BIT  = 31;
    localparam int CNT_LSB  = 16;
    localparam int CMD_HCR  = 0;
    localparam int CMD_CLF  = 1;
    localparam int CMD_BLF  = 2;
    localparam int CMD_OCR  = 3;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_ENA  = 2'd1,
        SEL_DIS  = 2'd2,
        SEL_CMD  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/usb_hc_irq_status.sv
// Sticky status bits, one per event source plus ownership change.
// Assumes events are single-cycle pulses; an event beats a same-cycle clear.
module usb_hc_irq_status #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_mask,
    input  logic               oc_set,
    input  logic               oc_clr,
    output logic [NUM_SRC-1:0] stat,
    output logic               oc_stat
);
    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_bit
            // Latch one source, clear on write-one, event has priority.
            always_ff @(posedge clk) begin
                if (!rst_n || sw_rst)
                    stat[i] <= 1'b0;
                else if (evt[i])
                    stat[i] <= 1'b1;
                else if (clr_we && clr_mask[i])
                    stat[i] <= 1'b0;
            end
        end
    endgenerate

    // Ownership-change status: set by request write, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)
            oc_stat <= 1'b0;
        else if (oc_set)
            oc_stat <= 1'b1;
        else if (oc_clr)
            oc_stat <= 1'b0;
    end

    // R3
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst && evt != '0) |=> ((stat & $past(evt)) == $past(evt)));
    // R10
    stat_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (stat == '0 && !oc_stat));
endmodule

// File: rtl/usb_hc_irq_enable.sv
// Enable bits written through a set-only and a clear-only alias.
// Bit NUM_SRC is ownership change, bit NUM_SRC+1 the master enable.
module usb_hc_irq_enable #(
    parameter int NUM_SRC = 7,
    localparam int EN_W   = NUM_SRC + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_rst,
    input  logic            set_we,
    input  logic            clr_we,
    input  logic [EN_W-1:0] mask,
    output logic [EN_W-1:0] en
);
    // Apply set or clear alias; the two never coincide (distinct addresses).
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)
            en <= '0;
        else if (set_we)
            en <= en | mask;
        else if (clr_we)
            en <= en & ~mask;
    end

    // R5
    dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((en & $past(mask)) == '0));
    // R4
    ena_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !sw_rst) |=> ((en & $past(mask)) == $past(mask)));
endmodule

// File: rtl/usb_hc_irq_cmd.sv
// Command word: software-reset sequencer, list flags, ownership request,
// and the wrapping overrun counter. Reset lasts RST_CYCLES cycles.
module usb_hc_irq_cmd #(
    parameter int RST_CYCLES = 8,
    parameter int CNT_W      = 2,
    localparam int BCW       = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             hcr_in,
    input  logic             clf_in,
    input  logic             blf_in,
    input  logic             ocr_in,
    input  logic             ovr_evt,
    output logic             busy,
    output logic             sw_rst,
    output logic             clf,
    output logic             blf,
    output logic             ocr,
    output logic             oc_set,
    output logic [CNT_W-1:0] ovr_cnt
);
    logic [BCW-1:0] bcnt;

    assign sw_rst = busy | (wr_cmd & hcr_in);
    assign oc_set = wr_cmd & ocr_in & ~sw_rst;

    // Reset sequencer: start on request, hold for RST_CYCLES cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bcnt <= '0;
        end else if (busy) begin
            if (bcnt == '0) busy <= 1'b0;
            else            bcnt <= bcnt - 1'b1;
        end else if (wr_cmd && hcr_in) begin
            busy <= 1'b1;
            bcnt <= BCW'(RST_CYCLES - 1);
        end
    end

    // Software flags load on each command write.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            clf <= 1'b0;
            blf <= 1'b0;
            ocr <= 1'b0;
        end else if (wr_cmd) begin
            clf <= clf_in;
            blf <= blf_in;
            ocr <= ocr_in;
        end
    end

    // Overrun counter, wrapping at its width.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)
            ovr_cnt <= '0;
        else if (ovr_evt)
            ovr_cnt <= ovr_cnt + 1'b1;
    end

    // R8
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !sw_rst) |=> (ovr_cnt == $past(ovr_cnt) + 1'b1));
    // R10
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcnt != '0) |=> busy);
    // R10
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_cmd && hcr_in) |=> busy);
endmodule

// File: rtl/usb_hc_irq_regs.sv
// Interrupt register set top: address decode, read mux, registered irq.
// Assumes single-cycle writes; reads are combinational on addr.
module usb_hc_irq_regs
    import usb_hc_irq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_SRC-1:0] evt,
    output logic              irq
);
    localparam int EN_W = NUM_SRC + 2;

    reg_sel_e            sel;
    logic                sw_rst, busy, clf, blf, ocr, oc_set, oc_stat;
    logic [1:0]          ovr_cnt;
    logic [NUM_SRC-1:0]  stat;
    logic [EN_W-1:0]     en, en_mask;
    logic                we_stat, we_ena, we_dis, we_cmd;
    logic                unused_wdata_bits;

    assign sel     = reg_sel_e'(addr[3:2]);
    assign we_cmd  = wr_en && sel == SEL_CMD;
    assign we_stat = wr_en && sel == SEL_STAT && !sw_rst;
    assign we_ena  = wr_en && sel == SEL_ENA  && !sw_rst;
    assign we_dis  = wr_en && sel == SEL_DIS  && !sw_rst;
    assign en_mask = {wr_data[MIE_BIT], wr_data[OC_BIT], wr_data[NUM_SRC-1:0]};
    assign unused_wdata_bits = ^{wr_data[29:NUM_SRC], addr};

    usb_hc_irq_cmd #(.RST_CYCLES(RST_CYCLES), .CNT_W(2)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_cmd(we_cmd),
        .hcr_in(wr_data[CMD_HCR]), .clf_in(wr_data[CMD_CLF]),
        .blf_in(wr_data[CMD_BLF]), .ocr_in(wr_data[CMD_OCR]),
        .ovr_evt(evt[0]), .busy(busy), .sw_rst(sw_rst), .clf(clf),
        .blf(blf), .ocr(ocr), .oc_set(oc_set), .ovr_cnt(ovr_cnt)
    );

    usb_hc_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .evt(evt),
        .clr_we(we_stat), .clr_mask(wr_data[NUM_SRC-1:0]),
        .oc_set(oc_set), .oc_clr(we_stat && wr_data[OC_BIT]),
        .stat(stat), .oc_stat(oc_stat)
    );

    usb_hc_irq_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .set_we(we_ena),
        .clr_we(we_dis), .mask(en_mask), .en(en)
    );

    // Read multiplexer over the four words.
    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_STAT: begin
                rd_data[NUM_SRC-1:0] = stat;
                rd_data[OC_BIT]      = oc_stat;
            end
            SEL_ENA: begin
                rd_data[NUM_SRC-1:0] = en[NUM_SRC-1:0];
                rd_data[OC_BIT]      = en[NUM_SRC];
                rd_data[MIE_BIT]     = en[NUM_SRC+1];
            end
            SEL_CMD: begin
                rd_data[CMD_HCR]          = busy;
                rd_data[CMD_CLF]          = clf;
                rd_data[CMD_BLF]          = blf;
                rd_data[CMD_OCR]          = ocr;
                rd_data[CNT_LSB+1:CNT_LSB] = ovr_cnt;
            end
            default: rd_data = '0;
        endcase
    end

    // Registered interrupt: master-gated OR of pending enabled sources.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= en[NUM_SRC+1] &&
                   (|(stat & en[NUM_SRC-1:0]) || (oc_stat && en[NUM_SRC]));
    end

    // R6
    mie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[NUM_SRC+1] |=> !irq);
    // R5
    dis_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DIS) |-> (rd_data == '0));
endmodule

// File: tb/usb_hc_irq_regs_bench.sv
module usb_hc_irq_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wr_data = '0;
    logic [6:0]  evt = '0;
    logic [31:0] rd_data;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    bit m_stat[7];
    bit m_en[7];
    bit m_oc, m_ocen, m_mie, m_clf, m_blf, m_ocr, m_busy, m_irq;
    int m_cnt, m_left;
    int rot = 0;

    usb_hc_irq_regs u_usb_hc_irq_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .evt(evt), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mread(int sel);
        logic [31:0] v = '0;
        case (sel)
            0: begin for (int i = 0; i < 7; i++) v[i] = m_stat[i]; v[30] = m_oc; end
            1: begin for (int i = 0; i < 7; i++) v[i] = m_en[i];
                     v[30] = m_ocen; v[31] = m_mie; end
            3: begin v[0] = m_busy; v[1] = m_clf; v[2] = m_blf; v[3] = m_ocr;
                     v[17:16] = 2'(m_cnt); end
            default: v = '0;
        endcase
        return v;
    endfunction

    // reference model update at each edge
    always @(posedge clk) begin
        int sel;
        bit pend, rst_now;
        sel = int'(addr[3:2]);
        pend = m_oc && m_ocen;
        for (int i = 0; i < 7; i++) if (m_stat[i] && m_en[i]) pend = 1;
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) begin m_stat[i] = 0; m_en[i] = 0; end
            {m_oc, m_ocen, m_mie, m_clf, m_blf, m_ocr, m_busy, m_irq} = '0;
            m_cnt = 0; m_left = 0;
        end else begin
            m_irq = m_mie && pend;
            rst_now = m_busy || (wr_en && sel == 3 && wr_data[0]);
            if (m_busy) begin
                if (m_left == 0) m_busy = 0; else m_left--;
            end else if (rst_now) begin
                m_busy = 1; m_left = 7;
            end
            if (rst_now) begin
                for (int i = 0; i < 7; i++) begin m_stat[i] = 0; m_en[i] = 0; end
                {m_oc, m_ocen, m_mie, m_clf, m_blf, m_ocr} = '0;
                m_cnt = 0;
            end else begin
                for (int i = 0; i < 7; i++) begin
                    if (wr_en && sel == 0 && wr_data[i]) m_stat[i] = 0;
                    if (evt[i]) m_stat[i] = 1;
                    if (wr_en && sel == 1 && wr_data[i]) m_en[i] = 1;
                    if (wr_en && sel == 2 && wr_data[i]) m_en[i] = 0;
                end
                if (wr_en && sel == 0 && wr_data[30]) m_oc = 0;
                if (wr_en && sel == 3 && wr_data[3]) m_oc = 1;
                if (wr_en && sel == 1) begin
                    if (wr_data[30]) m_ocen = 1;
                    if (wr_data[31]) m_mie = 1;
                end
                if (wr_en && sel == 2) begin
                    if (wr_data[30]) m_ocen = 0;
                    if (wr_data[31]) m_mie = 0;
                end
                if (wr_en && sel == 3) begin
                    m_clf = wr_data[1]; m_blf = wr_data[2]; m_ocr = wr_data[3];
                end
                if (evt[0]) m_cnt = (m_cnt + 1) % 4;
            end
        end
    end

    // compare on every cycle, away from the edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        #1;
        if (rst_n) begin
            exp_rd = mread(int'(addr[3:2]));
            vectors++;
            if (rd_data !== exp_rd || irq !== m_irq) begin
                fails++;
                $display("FAIL %s addr=%h rd=%h exp=%h irq=%b exp_irq=%b",
                         tag, addr, rd_data, exp_rd, irq, m_irq);
            end
        end
    end

    task automatic drive(bit we, logic [3:0] a, logic [31:0] d, logic [6:0] e);
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; evt = e;
        @(negedge clk);
        wr_en = 0; evt = '0; addr = 4'(rot * 4); rot = (rot + 1) % 4;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 0; evt = '0; addr = 4'(rot * 4); rot = (rot + 1) % 4;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1"; idle(4);
        tag = "R2";
        for (int s = 0; s < 7; s++) begin drive(0, 4'h0, 0, 7'(1 << s)); idle(1); end
        idle(4);
        tag = "R3";
        drive(1, 4'h0, 32'h0000_0013, '0); idle(2);
        drive(1, 4'h0, 32'h0000_0004, 7'h04); idle(2);
        drive(1, 4'h0, 32'h0000_007f, '0); idle(2);
        tag = "R4";
        drive(1, 4'h4, 32'h0000_0005, '0); drive(1, 4'h4, 32'h0, '0);
        drive(1, 4'h4, 32'h0000_0022, '0); idle(4);
        tag = "R5";
        drive(1, 4'h8, 32'h0000_0021, '0); drive(0, 4'h8, 0, '0); idle(4);
        tag = "R6";
        drive(0, 4'h0, 0, 7'h04); idle(3);
        drive(1, 4'h4, 32'h8000_0000, '0); idle(3);
        drive(1, 4'h8, 32'h8000_0000, '0); idle(3);
        drive(1, 4'h4, 32'h8000_0000, '0); drive(1, 4'h0, 32'h4, '0); idle(3);
        tag = "R7";
        drive(1, 4'hC, 32'h0000_0008, '0); idle(2);
        drive(1, 4'h4, 32'h4000_0000, '0); idle(3);
        drive(1, 4'h0, 32'h4000_0000, '0); idle(3);
        tag = "R8";
        for (int k = 0; k < 5; k++) drive(0, 4'hC, 0, 7'h01);
        idle(4);
        tag = "R9";
        drive(1, 4'hC, 32'h0000_0006, '0); idle(2);
        drive(1, 4'hC, 32'h0000_0002, '0); idle(2);
        tag = "R10";
        drive(0, 4'h0, 0, 7'h7f); drive(1, 4'h4, 32'hC000_007f, '0); idle(2);
        drive(1, 4'hC, 32'h0000_0001, 7'h01);
        drive(1, 4'h4, 32'h8000_00ff, 7'h7f); drive(0, 4'hC, 0, 7'h01);
        idle(12);
        tag = "R6";
        for (int k = 0; k < 400; k++) begin
            logic [31:0] d;
            d = $urandom;
            if (d[0] && ($urandom % 8 != 0)) d[0] = 0;
            drive($urandom % 2 == 0, 4'(($urandom % 4) * 4), d, 7'($urandom));
        end
        idle(12);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not finish exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule